// File: doc/BRIEF.md
# Edge-Qualified Counter Capture Channel

This block is one channel of a general-purpose timer. It either captures the timer's free-running 16-bit count when a qualified input edge arrives, or drives a simple output level. A 2-bit mode field chooses between them. Mode 0 makes the channel an output. The other three modes pick the capture source: the channel's own pin, the pin of the channel next to it, or an internal trigger line.

In capture mode, each of the three raw lines passes through a two-stage synchronizer. The edge on the selected line is then detected with the polarity setting: rising when the polarity bit is 0, falling when it is 1. Qualifying edges feed a small divider, so only every 1st, 2nd, 4th or 8th edge causes a capture. Each capture copies the counter into a 16-bit register and sets a sticky flag. A capture that finds the flag already set also raises an overcapture flag. The divider is held at zero whenever the channel is disabled.

Configuration is written as a whole word with one strobe. The mode field is locked while the channel is enabled. The divider, polarity and enable fields always take the written value.

Top module: `capChan`

## Requirements
- R1: `chanOut` is 0 whenever the channel is disabled or in any capture mode (mode != 0). With mode 0 and enable 1, `chanOut` equals `refLevel` XOR polarity.
- R2: The capture source is picked by mode. Mode 1 uses `ownRaw`, mode 2 uses `neighRaw` and mode 3 uses `trigIn`. Edges on lines that are not selected never cause a capture.
- R3: In mode 3, no capture occurs while `trigValid` is 0.
- R4: With polarity 0 only rising edges of the source qualify. With polarity 1 only falling edges qualify.
- R5: The divider field picks a capture on every qualified edge (0), every 2nd edge (1), every 4th edge (2) or every 8th edge (3). Counting starts after the divider was last cleared.
- R6: The edge divider is cleared while enable is 0. Edges counted before a disable do not count toward the next capture.
- R7: A source change that is applied just after a falling clock edge is captured at the third rising clock edge after it. `capVal` then holds the `counterIn` value present at that edge, and `capFlag` is 1 from that edge on.
- R8: `capFlag` is sticky. A capture while `capFlag` is already 1 sets `ovrFlag`.
- R9: A cycle with `flagClr` high and no capture clears both `capFlag` and `ovrFlag`. If a capture happens in the same cycle, `capFlag` ends at 1 and `ovrFlag` ends at 0.
- R10: A configuration write while enable is 1 leaves the mode (`cfgModeOut`) unchanged. When enable is 0, the write loads the new mode.
- R11: After reset, `capVal` = 0, both flags = 0, `chanOut` = 0 and `cfgModeOut` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| counterIn | input | 16 | Free-running timer count |
| ownRaw | input | 1 | The channel's own raw pin |
| neighRaw | input | 1 | Adjacent channel's raw pin |
| trigIn | input | 1 | Internal trigger line |
| trigValid | input | 1 | An internal trigger source is selected |
| refLevel | input | 1 | Reference level for output mode |
| cfgWr | input | 1 | Configuration write strobe |
| cfgModeIn | input | 2 | Mode to write (0 output, 1 own, 2 neighbour, 3 trigger) |
| cfgDivIn | input | 2 | Edge divider select to write |
| cfgPolIn | input | 1 | Polarity to write |
| cfgEnIn | input | 1 | Enable to write |
| flagClr | input | 1 | Clear capture and overcapture flags |
| capVal | output | 16 | Captured counter value |
| capFlag | output | 1 | Sticky capture flag |
| ovrFlag | output | 1 | Overcapture flag |
| chanOut | output | 1 | Output-mode level |
| cfgModeOut | output | 2 | Current mode field |

## Verification
The hardest case to reach is proving that the divider really clears on disable. Its count is not visible, so it can only be inferred from how many further edges the next capture needs. The stimulus sets the divide-by-4 setting and gives three edges. It then disables and re-enables the channel and checks that one edge raises no flag but three more do. Routing and the trigger-valid gate are tested the same way: pulses go to the lines that are not selected, and the bench confirms the flag stays clear.

// File: rtl/capChanPkg.sv
package capChanPkg;
  localparam int CNT_W = 16;
  localparam logic [1:0] MODE_OUT   = 2'b00;
  localparam logic [1:0] MODE_OWN   = 2'b01;
  localparam logic [1:0] MODE_NEIGH = 2'b10;
  localparam logic [1:0] MODE_TRIG  = 2'b11;

  typedef struct packed {
    logic capture;
    logic clrFlags;
  } capStrobe_t;
endpackage

// File: rtl/capCtrl.sv
module capCtrl
  import capChanPkg::*;
#(
  parameter int NUM_SRC     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2,
  localparam int PRE_W      = (1 << DIV_W) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [1:0]         cfgModeIn,
  input  logic [DIV_W-1:0]   cfgDivIn,
  input  logic               cfgPolIn,
  input  logic               cfgEnIn,
  input  logic               flagClr,
  input  logic [NUM_SRC-1:0] rawIn,
  input  logic               trigValid,
  output logic [1:0]         modeQ,
  output logic               polQ,
  output logic               enQ,
  output capStrobe_t         strb
);
  logic [DIV_W-1:0]   divQ;
  logic [NUM_SRC-1:0] syncOut;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] srcEdge;
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   divLast;
  logic               selEdge;
  logic               qualified;

  // configuration fields; mode locked while enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_OUT;
      divQ  <= '0;
      polQ  <= 1'b0;
      enQ   <= 1'b0;
    end else if (cfgWr) begin
      if (!enQ) modeQ <= cfgModeIn;
      divQ <= cfgDivIn;
      polQ <= cfgPolIn;
      enQ  <= cfgEnIn;
    end
  end

  // per-source synchronizer and edge history, so a source switch makes no false edge
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [SYNC_STAGES-1:0] syncQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ    <= '0;
        prevQ[s] <= 1'b0;
      end else begin
        syncQ    <= {syncQ[SYNC_STAGES-2:0], rawIn[s]};
        prevQ[s] <= syncQ[SYNC_STAGES-1];
      end
    end
    assign syncOut[s] = syncQ[SYNC_STAGES-1];
    assign srcEdge[s] = polQ ? (prevQ[s] & ~syncOut[s]) : (syncOut[s] & ~prevQ[s]);
  end

  always_comb begin
    case (modeQ)
      MODE_OWN:   selEdge = srcEdge[0];
      MODE_NEIGH: selEdge = srcEdge[1];
      MODE_TRIG:  selEdge = srcEdge[2] & trigValid;
      default:    selEdge = 1'b0;
    endcase
  end

  assign qualified = enQ & selEdge;
  assign divLast   = ~({PRE_W{1'b1}} << divQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 preCnt <= '0;
    else if (!enQ)             preCnt <= '0;
    else if (qualified) begin
      if (preCnt >= divLast)   preCnt <= '0;
      else                     preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strb.capture  = qualified && (preCnt >= divLast);
    strb.clrFlags = flagClr;
  end
endmodule

// File: rtl/capData.sv
module capData
  import capChanPkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  capStrobe_t    strb,
  input  logic [CW-1:0] counterIn,
  output logic [CW-1:0] capVal,
  output logic          capFlag,
  output logic          ovrFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capVal  <= '0;
      capFlag <= 1'b0;
      ovrFlag <= 1'b0;
    end else if (strb.capture) begin
      capVal  <= counterIn;
      capFlag <= 1'b1;
      ovrFlag <= strb.clrFlags ? 1'b0 : (ovrFlag | capFlag);
    end else if (strb.clrFlags) begin
      capFlag <= 1'b0;
      ovrFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/capChan.sv
module capChan
  import capChanPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] counterIn,
  input  logic        ownRaw,
  input  logic        neighRaw,
  input  logic        trigIn,
  input  logic        trigValid,
  input  logic        refLevel,
  input  logic        cfgWr,
  input  logic [1:0]  cfgModeIn,
  input  logic [1:0]  cfgDivIn,
  input  logic        cfgPolIn,
  input  logic        cfgEnIn,
  input  logic        flagClr,
  output logic [15:0] capVal,
  output logic        capFlag,
  output logic        ovrFlag,
  output logic        chanOut,
  output logic [1:0]  cfgModeOut
);
  capStrobe_t strb;
  logic [1:0] modeQ;
  logic       polQ;
  logic       enQ;

  capCtrl #(.NUM_SRC(3), .SYNC_STAGES(2), .DIV_W(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgModeIn(cfgModeIn),
    .cfgDivIn(cfgDivIn), .cfgPolIn(cfgPolIn), .cfgEnIn(cfgEnIn),
    .flagClr(flagClr), .rawIn({trigIn, neighRaw, ownRaw}),
    .trigValid(trigValid), .modeQ(modeQ), .polQ(polQ), .enQ(enQ),
    .strb(strb)
  );

  capData #(.CW(16)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .counterIn(counterIn),
    .capVal(capVal), .capFlag(capFlag), .ovrFlag(ovrFlag)
  );

  assign chanOut    = (enQ && modeQ == MODE_OUT) ? (refLevel ^ polQ) : 1'b0;
  assign cfgModeOut = modeQ;
endmodule

// File: rtl/capChanChk.sv
module capChanChk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] counterIn,
  input logic [15:0] capVal,
  input logic        capFlag,
  input logic        ovrFlag,
  input logic        chanOut,
  input logic [1:0]  cfgModeOut,
  input logic        flagClr,
  input logic        trigValid,
  input logic        chanEn,
  input logic        capStrobe
);
  a_r1_quiet_in_capture: assert property (@(posedge clk) disable iff (!rstN)
    (cfgModeOut != 2'b00) |-> !chanOut);

  a_r3_trig_gate: assert property (@(posedge clk) disable iff (!rstN)
    (cfgModeOut == 2'b11 && !trigValid) |-> !capStrobe);

  a_r7_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |=> (capVal == $past(counterIn)) && capFlag);

  a_r8_ovr_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(capFlag));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !capStrobe) |=> (!capFlag && !ovrFlag));

  a_r10_mode_locked: assert property (@(posedge clk) disable iff (!rstN)
    $past(chanEn) |-> $stable(cfgModeOut));
endmodule

bind capChan capChanChk i_chk (
  .clk(clk), .rstN(rstN), .counterIn(counterIn), .capVal(capVal),
  .capFlag(capFlag), .ovrFlag(ovrFlag), .chanOut(chanOut),
  .cfgModeOut(cfgModeOut), .flagClr(flagClr), .trigValid(trigValid),
  .chanEn(enQ), .capStrobe(strb.capture)
);

// File: tb/test_capChan.sv
`timescale 1ns/1ps
module test_capChan;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cnt = '0;
  logic ownRaw = 0, neighRaw = 0, trigIn = 0, trigValid = 0, refLevel = 0;
  logic cfgWr = 0, cfgPolIn = 0, cfgEnIn = 0, flagClr = 0;
  logic [1:0] cfgModeIn = '0, cfgDivIn = '0;
  logic [15:0] capVal;
  logic capFlag, ovrFlag, chanOut;
  logic [1:0] cfgModeOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  capChan i_capChan (
    .clk(clk), .rstN(rstN), .counterIn(cnt), .ownRaw(ownRaw), .neighRaw(neighRaw),
    .trigIn(trigIn), .trigValid(trigValid), .refLevel(refLevel), .cfgWr(cfgWr),
    .cfgModeIn(cfgModeIn), .cfgDivIn(cfgDivIn), .cfgPolIn(cfgPolIn), .cfgEnIn(cfgEnIn),
    .flagClr(flagClr), .capVal(capVal), .capFlag(capFlag), .ovrFlag(ovrFlag),
    .chanOut(chanOut), .cfgModeOut(cfgModeOut)
  );

  // [11:10] mode, [9:8] div, [7] pol, [6:2] pulses, [1] expFlag, [0] expOvr
  localparam logic [11:0] VEC [12] = '{
    {2'd1, 2'd0, 1'b0, 5'd1,  1'b1, 1'b0},
    {2'd1, 2'd0, 1'b0, 5'd2,  1'b1, 1'b1},
    {2'd1, 2'd1, 1'b0, 5'd1,  1'b0, 1'b0},
    {2'd1, 2'd1, 1'b0, 5'd2,  1'b1, 1'b0},
    {2'd1, 2'd2, 1'b0, 5'd3,  1'b0, 1'b0},
    {2'd1, 2'd2, 1'b0, 5'd4,  1'b1, 1'b0},
    {2'd1, 2'd3, 1'b0, 5'd7,  1'b0, 1'b0},
    {2'd1, 2'd3, 1'b0, 5'd8,  1'b1, 1'b0},
    {2'd1, 2'd3, 1'b0, 5'd16, 1'b1, 1'b1},
    {2'd1, 2'd0, 1'b1, 5'd1,  1'b1, 1'b0},
    {2'd2, 2'd0, 1'b0, 5'd1,  1'b1, 1'b0},
    {2'd3, 2'd1, 1'b1, 5'd2,  1'b1, 1'b0}
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cnt = cnt + 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic writeCfg(input logic [1:0] m, input logic [1:0] d, input logic p, input logic e);
    cfgWr = 1; cfgModeIn = m; cfgDivIn = d; cfgPolIn = p; cfgEnIn = e;
    tick();
    cfgWr = 0;
  endtask

  task automatic clearFlags();
    flagClr = 1;
    tick();
    flagClr = 0;
  endtask

  task automatic setSrc(input int idx, input logic v);
    case (idx)
      0: ownRaw = v;
      1: neighRaw = v;
      default: trigIn = v;
    endcase
  endtask

  task automatic pulse(input int idx);
    setSrc(idx, 1'b1); ticks(4);
    setSrc(idx, 1'b0); ticks(4);
  endtask

  task automatic restart(input logic [1:0] m, input logic [1:0] d, input logic p);
    writeCfg(m, d, p, 1'b0);
    writeCfg(m, d, p, 1'b1);
    clearFlags();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ticks(3);
    // R11 reset state
    check(capVal, 16'h0, "R11 capVal");
    check({15'b0, capFlag}, 16'h0, "R11 capFlag");
    check({15'b0, ovrFlag}, 16'h0, "R11 ovrFlag");
    check({15'b0, chanOut}, 16'h0, "R11 chanOut");
    check({14'b0, cfgModeOut}, 16'h0, "R11 mode");
    rstN = 1;
    ticks(2);

    // table walk: R2 R4 R5 R8
    trigValid = 1;
    foreach (VEC[v]) begin
      restart(VEC[v][11:10], VEC[v][9:8], VEC[v][7]);
      for (int p = 0; p < int'(VEC[v][6:2]); p++) pulse(int'(VEC[v][11:10]) - 1);
      ticks(2);
      check({15'b0, capFlag}, {15'b0, VEC[v][1]}, $sformatf("R5 vec%0d capFlag", v));
      check({15'b0, ovrFlag}, {15'b0, VEC[v][0]}, $sformatf("R8 vec%0d ovrFlag", v));
    end

    // R9 clear
    clearFlags();
    check({14'b0, capFlag, ovrFlag}, 16'h0, "R9 clear both flags");

    // R4 polarity: rising edge ignored with polarity 1
    restart(2'd1, 2'd0, 1'b1);
    setSrc(0, 1'b1); ticks(5);
    check({15'b0, capFlag}, 16'h0, "R4 rising ignored when pol=1");
    setSrc(0, 1'b0); ticks(4);
    check({15'b0, capFlag}, 16'h1, "R4 falling captured when pol=1");

    // R7 capture latency and value
    restart(2'd1, 2'd0, 1'b0);
    cnt = 16'h1234; ownRaw = 1;
    ticks(2);
    check({15'b0, capFlag}, 16'h0, "R7 no capture before third edge");
    tick();
    check({15'b0, capFlag}, 16'h1, "R7 flag at third edge");
    check(capVal, 16'h1236, "R7 captured value");
    ownRaw = 0; ticks(4);

    // R2 routing
    restart(2'd2, 2'd0, 1'b0);
    pulse(0); pulse(2);
    check({15'b0, capFlag}, 16'h0, "R2 mode2 ignores own and trig");
    pulse(1);
    check({15'b0, capFlag}, 16'h1, "R2 mode2 captures neighbour");
    restart(2'd1, 2'd0, 1'b0);
    pulse(1);
    check({15'b0, capFlag}, 16'h0, "R2 mode1 ignores neighbour");

    // R3 trigger gate
    trigValid = 0;
    restart(2'd3, 2'd0, 1'b0);
    pulse(2);
    check({15'b0, capFlag}, 16'h0, "R3 no capture without trigValid");
    trigValid = 1;
    pulse(2);
    check({15'b0, capFlag}, 16'h1, "R3 capture with trigValid");

    // R6 divider cleared by disable
    restart(2'd1, 2'd2, 1'b0);
    for (int p = 0; p < 3; p++) pulse(0);
    writeCfg(2'd1, 2'd2, 1'b0, 1'b0);
    writeCfg(2'd1, 2'd2, 1'b0, 1'b1);
    pulse(0);
    check({15'b0, capFlag}, 16'h0, "R6 count restarted after disable");
    for (int p = 0; p < 3; p++) pulse(0);
    check({15'b0, capFlag}, 16'h1, "R6 capture after four fresh edges");

    // R10 mode lock
    writeCfg(2'd0, 2'd0, 1'b0, 1'b1);
    check({14'b0, cfgModeOut}, 16'h1, "R10 mode write ignored while enabled");
    writeCfg(2'd0, 2'd0, 1'b0, 1'b0);
    check({14'b0, cfgModeOut}, 16'h1, "R10 disabling write keeps mode");
    writeCfg(2'd0, 2'd0, 1'b0, 1'b1);
    check({14'b0, cfgModeOut}, 16'h0, "R10 mode loads while disabled");

    // R1 output
    refLevel = 1; tick();
    check({15'b0, chanOut}, 16'h1, "R1 ref1 pol0");
    refLevel = 0; tick();
    check({15'b0, chanOut}, 16'h0, "R1 ref0 pol0");
    writeCfg(2'd0, 2'd0, 1'b1, 1'b1);
    check({15'b0, chanOut}, 16'h1, "R1 ref0 pol1");
    writeCfg(2'd0, 2'd0, 1'b1, 1'b0);
    check({15'b0, chanOut}, 16'h0, "R1 disabled forces low");
    refLevel = 1;
    writeCfg(2'd1, 2'd0, 1'b0, 1'b1);
    check({15'b0, chanOut}, 16'h0, "R1 low in capture mode");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule